// File: doc/BRIEF.md
# SPI Two-Stage Serial Clock Prescaler

This block derives the serial clock of an SPI master from the main clock through two divider stages in series. The first stage is a power-of-two prescaler: a 2-bit ratio code picks division by 2, 4, 8 or 16 and produces a one-cycle tick at that rate. The second stage counts these ticks. It flips the serial clock every (B+1) ticks, where B is a 6-bit rate code, so each full serial clock period lasts 2*(B+1) ticks. The fastest clock is the main clock over 20 and the slowest is the main clock over 2048.

A shift engine beside this block uses two one-cycle strobes. The first marks the edge where the serial clock leaves its idle level. The second marks the edge where it returns to it. A polarity input sets the idle level. The divider settings are taken only while the block is disabled and are frozen while it is enabled. After enable, a ready flag rises once one prescaler period has elapsed. The serial clock toggles only while the block is enabled, ready and a transfer is requested. At all other times it rests at its idle level and no strobes are produced.

Top module: `spi_sck_prescaler`

## Requirements
- R1: While reset is held, and afterwards until a load takes place, the frozen settings are ratio code 0 and rate code 4. Releasing reset with enable already high therefore gives a ready delay of 2 cycles and a serial period of 20 cycles, whatever is on the setting inputs.
- R2: The prescaler divides the main clock by (2 << div_sel): codes 0, 1, 2 and 3 divide by 2, 4, 8 and 16.
- R3: With an effective rate code B, the serial clock stays (B+1)*(2 << div_sel) main-clock cycles at each level, for a full period of 2*(B+1)*(2 << div_sel) cycles.
- R4: A rate code below 4 behaves exactly like rate code 4, so the period is never shorter than 20 main-clock cycles.
- R5: Whenever the block is disabled or no transfer is requested, the serial clock sits at its idle level. The idle level is low when cpol is 0 and high when cpol is 1.
- R6: The lead strobe is high for one cycle, in the same cycle the serial clock first shows its non-idle level. The trail strobe is high for one cycle, in the same cycle the clock first shows its idle level again. The two strobes are never high together.
- R7: While enable is high, changes on div_sel and brg_sel have no effect. The values present in the last cycle with enable low stay in force.
- R8: After enable goes high, ready is first seen high after exactly (2 << div_sel) rising clock edges. One edge after enable goes low, ready is low again.
- R9: No strobe occurs and the serial clock does not leave idle while ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; settings load while low |
| run | input | 1 | Transfer request; the serial clock toggles while high and ready |
| div_sel | input | 2 | Prescaler ratio code, division by 2 << div_sel |
| brg_sel | input | 6 | Rate code B, half period of B+1 prescaler ticks (minimum 4) |
| cpol | input | 1 | Idle level of the serial clock |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on the edge leaving idle |
| trail_stb | output | 1 | One-cycle strobe on the edge returning to idle |
| ready | output | 1 | Divider settled after enable |

## Verification
Every ratio code is combined with rate codes that sit below the floor, on it, just above it, in the middle and at the top. For each combination the ready delay, the lead-to-trail time and the lead-to-lead time are measured. Together these separate a wrong prescaler ratio, a wrong second-stage count and a missing or misplaced clamp. Both polarities are used, so a wrong idle level is caught. A reset released with enable high shows the reset settings. Changing the setting inputs in the middle of a run must leave the measured period unchanged.

// File: rtl/spi_sck_pkg.sv
// Package: constants shared by the serial clock prescaler.
// Assumes nothing beyond being compiled first.
package spi_sck_pkg;
    localparam int DIV_W_DFLT  = 2;   // width of the ratio code
    localparam int BRG_W_DFLT  = 6;   // width of the rate code
    localparam int BRG_MIN_DFLT = 4;  // smallest legal rate code
    localparam int DIV_RST_DFLT = 0;  // ratio code after reset
    localparam int BRG_RST_DFLT = 4;  // rate code after reset

    // Level of the serial clock relative to its idle level
    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } sck_phase_e;
endpackage

// File: rtl/spi_sck_cfg.sv
// Settings holder: loads the ratio and rate codes while the block is
// disabled and freezes them while enabled. Rate codes below BRG_MIN are
// raised to BRG_MIN. Assumes a synchronous active-low reset.
module spi_sck_cfg #(
    parameter int DIV_W   = 2,
    parameter int BRG_W   = 6,
    parameter int BRG_MIN = 4,
    parameter int DIV_RST = 0,
    parameter int BRG_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_in,
    input  logic [BRG_W-1:0] brg_in,
    output logic [DIV_W-1:0] div_q,
    output logic [BRG_W-1:0] brg_q
);
    localparam logic [BRG_W-1:0] BRG_FLOOR = BRG_W'(BRG_MIN);

    logic [BRG_W-1:0] brg_legal;

    generate
        if (BRG_MIN > 0) begin : g_clamp
            // Raise rate codes below the floor to the floor
            always_comb brg_legal = (brg_in < BRG_FLOOR) ? BRG_FLOOR : brg_in;
        end else begin : g_pass
            // No floor configured: take the code unchanged
            always_comb brg_legal = brg_in;
        end
    endgenerate

    // Load settings only while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DIV_RST);
            brg_q <= BRG_W'(BRG_RST);
        end else if (!enable) begin
            div_q <= div_in;
            brg_q <= brg_legal;
        end
    end
endmodule

// File: rtl/spi_sck_pre.sv
// First stage: power-of-two prescaler. Emits a one-cycle tick every
// (2 << div) main clocks while enabled, and raises ready at the first tick
// after enable. Assumes div is stable while enabled.
module spi_sck_pre #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             ready
);
    localparam int PRE_W = (1 << DIV_W) + 1;

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] last;

    // Terminal count of the prescaler for the current ratio code
    always_comb last = (PRE_W'(2) << div) - PRE_W'(1);

    // Tick on the terminal count
    always_comb tick = enable && (cnt == last);

    // Prescaler counter, held at zero while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt <= '0;
        end else if (cnt == last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PRE_W'(1);
        end
    end

    // Ready flag: set by the first tick, cleared when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            ready <= 1'b0;
        end else if (tick) begin
            ready <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_sck_edge.sv
// Second stage: counts prescaler ticks and flips the serial clock phase
// every (brg + 1) ticks while active. Produces registered lead and trail
// strobes aligned with the phase change. Assumes brg is stable while active.
module spi_sck_edge
    import spi_sck_pkg::*;
#(
    parameter int BRG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic [BRG_W-1:0] brg,
    output sck_phase_e       phase,
    output logic             lead,
    output logic             trail
);
    logic [BRG_W-1:0] hcnt;

    // Half-period counter, phase and edge strobes
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            hcnt  <= '0;
            phase <= PH_IDLE;
            lead  <= 1'b0;
            trail <= 1'b0;
        end else begin
            lead  <= 1'b0;
            trail <= 1'b0;
            if (tick) begin
                if (hcnt == brg) begin
                    hcnt  <= '0;
                    phase <= (phase == PH_IDLE) ? PH_ACTIVE : PH_IDLE;
                    lead  <= (phase == PH_IDLE);
                    trail <= (phase == PH_ACTIVE);
                end else begin
                    hcnt <= hcnt + BRG_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/spi_sck_prescaler.sv
// Top: two-stage serial clock generator for an SPI master. The settings
// holder feeds a power-of-two prescaler and an even-ratio edge counter. The
// serial clock is the phase XOR the polarity, so it rests at cpol when idle.
// Assumes a synchronous active-low reset and settings changed only while
// disabled (changes while enabled are ignored).
module spi_sck_prescaler
    import spi_sck_pkg::*;
#(
    parameter int DIV_W   = DIV_W_DFLT,
    parameter int BRG_W   = BRG_W_DFLT,
    parameter int BRG_MIN = BRG_MIN_DFLT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [BRG_W-1:0] brg_sel,
    input  logic             cpol,
    output logic             sck,
    output logic             lead_stb,
    output logic             trail_stb,
    output logic             ready
);
    logic [DIV_W-1:0] cfg_div;
    logic [BRG_W-1:0] cfg_brg;
    logic             pre_tick;
    logic             active;
    sck_phase_e       phase;

    spi_sck_cfg #(
        .DIV_W   (DIV_W),
        .BRG_W   (BRG_W),
        .BRG_MIN (BRG_MIN),
        .DIV_RST (DIV_RST_DFLT),
        .BRG_RST (BRG_RST_DFLT)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .div_in (div_sel),
        .brg_in (brg_sel),
        .div_q  (cfg_div),
        .brg_q  (cfg_brg)
    );

    spi_sck_pre #(
        .DIV_W (DIV_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .div    (cfg_div),
        .tick   (pre_tick),
        .ready  (ready)
    );

    // Second stage runs only when enabled, settled and a transfer is asked
    always_comb active = enable && ready && run;

    spi_sck_edge #(
        .BRG_W (BRG_W)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .tick   (pre_tick),
        .brg    (cfg_brg),
        .phase  (phase),
        .lead   (lead_stb),
        .trail  (trail_stb)
    );

    // Apply polarity to the phase
    always_comb sck = cpol ^ (phase == PH_ACTIVE);
endmodule

// File: rtl/spi_sck_prescaler_chk.sv
// Checker for the serial clock prescaler, bound to the top module.
// Observes ports and the frozen settings. Purely passive.
module spi_sck_prescaler_chk #(
    parameter int DIV_W   = 2,
    parameter int BRG_W   = 6,
    parameter int BRG_MIN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             cpol,
    input logic             sck,
    input logic             lead_stb,
    input logic             trail_stb,
    input logic             ready,
    input logic [DIV_W-1:0] cfg_div,
    input logic [BRG_W-1:0] cfg_brg
);
    // R6: strobes never coincide
    assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));

    // R6: lead strobe lasts one cycle
    assert_lead_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |=> !lead_stb);

    // R6: the lead strobe shows with the non-idle level
    assert_lead_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> (sck != cpol));

    // R6: the trail strobe shows with the idle level
    assert_trail_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (sck == cpol));

    // R5: disabled means idle level one edge later
    assert_idle_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (sck == cpol));

    // R8: ready clears one edge after disable
    assert_ready_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !ready);

    // R9: no strobes without ready
    assert_no_strobe_unready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!lead_stb && !trail_stb));

    // R7: settings frozen while enabled
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ($stable(cfg_div) && $stable(cfg_brg)));

    // R4: the frozen rate code never falls below the floor
    assert_brg_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_brg >= BRG_W'(BRG_MIN));
endmodule

bind spi_sck_prescaler spi_sck_prescaler_chk #(
    .DIV_W   (DIV_W),
    .BRG_W   (BRG_W),
    .BRG_MIN (BRG_MIN)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cpol      (cpol),
    .sck       (sck),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb),
    .ready     (ready),
    .cfg_div   (cfg_div),
    .cfg_brg   (cfg_brg)
);

// File: tb/test_spi_sck_prescaler.sv
// Bench: sweeps ratio and rate codes, measuring ready delay and serial
// clock half and full periods against values computed arithmetically.
module test_spi_sck_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       run = 1'b0;
    logic [1:0] div_sel = '0;
    logic [5:0] brg_sel = '0;
    logic       cpol = 1'b0;
    logic       sck;
    logic       lead_stb;
    logic       trail_stb;
    logic       ready;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    spi_sck_prescaler i_spi_sck_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .run       (run),
        .div_sel   (div_sel),
        .brg_sel   (brg_sel),
        .cpol      (cpol),
        .sck       (sck),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb),
        .ready     (ready)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges until ready; check idle behaviour meanwhile (R9)
    task automatic wait_ready(input int exp, input bit p, input string req);
        int n = 0;
        bit quiet = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (lead_stb || trail_stb || sck != p) quiet = 1'b0;
        end while (!ready && n < 100);
        check(n == exp, req, n, exp);
        check(quiet, "R9 idle before ready", int'(quiet), 1);
    endtask

    // Count negedges until the chosen strobe (0 lead, 1 trail)
    task automatic count_to(input bit which, output int n, output bit clash);
        n = 0;
        clash = 1'b0;
        do begin
            @(negedge clk);
            n++;
            if (lead_stb && trail_stb) clash = 1'b1;
        end while (!(which ? trail_stb : lead_stb) && n < 5000);
    endtask

    // Measure half and full periods of a running clock
    task automatic measure(input int half, input bit p, input string req);
        int  n1;
        int  n2;
        int  dummy;
        bit  c0;
        bit  c1;
        bit  c2;
        count_to(1'b0, dummy, c0);
        check(sck != p, "R6 level at lead", int'(sck), int'(!p));
        count_to(1'b1, n1, c1);
        check(sck == p, "R6 level at trail", int'(sck), int'(p));
        check(n1 == half, req, n1, half);
        count_to(1'b0, n2, c2);
        check(n1 + n2 == 2 * half, req, n1 + n2, 2 * half);
        check(!(c0 || c1 || c2), "R6 strobes exclusive", int'(c0 || c1 || c2), 0);
    endtask

    // One configuration: load, enable, run, measure, stop
    task automatic run_cfg(input int d, input int b, input bit p, input bit poke);
        int ratio = 2 << d;
        int beff  = (b < 4) ? 4 : b;
        int half  = (beff + 1) * ratio;
        enable  = 1'b0;
        run     = 1'b0;
        div_sel = 2'(d);
        brg_sel = 6'(b);
        cpol    = p;
        @(negedge clk);
        check(ready == 1'b0, "R8 ready low when disabled", int'(ready), 0);
        check(sck == p, "R5 idle level when disabled", int'(sck), int'(p));
        enable = 1'b1;
        if (poke) begin
            div_sel = 2'(3 - d);
            brg_sel = 6'(63 - b);
        end
        wait_ready(ratio, p, "R8 R2 ready delay");
        run = 1'b1;
        if (poke) measure(half, p, "R7 settings frozen while enabled");
        else if (b < 4) measure(half, p, "R4 rate floor");
        else measure(half, p, "R3 R2 serial period");
        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(sck == p && !lead_stb && !trail_stb, "R5 idle after run drops",
              int'(sck), int'(p));
        enable = 1'b0;
    endtask

    initial begin
        int brg_list[9] = '{0, 3, 4, 5, 7, 12, 33, 62, 63};
        // R1: reset with enable high and non-default setting inputs
        enable  = 1'b1;
        run     = 1'b1;
        div_sel = 2'd3;
        brg_sel = 6'd63;
        cpol    = 1'b0;
        repeat (3) @(negedge clk);
        check(sck == 1'b0 && !lead_stb && !trail_stb && !ready,
              "R1 reset state", int'(sck | lead_stb | trail_stb | ready), 0);
        rst_n = 1'b1;
        wait_ready(2, 1'b0, "R1 reset ratio code");
        measure(10, 1'b0, "R1 reset rate code");
        run = 1'b0;
        enable = 1'b0;
        @(negedge clk);

        for (int d = 0; d < 4; d++) begin
            for (int i = 0; i < 9; i++) begin
                run_cfg(d, brg_list[i], 1'((d + i) % 2), 1'b0);
            end
        end
        // R7: poke the setting inputs while enabled
        run_cfg(1, 9, 1'b1, 1'b1);
        run_cfg(0, 4, 1'b0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule